// File: doc/BRIEF.md
# Super I/O configuration register port

This block is the configuration front end of a multi-function peripheral chip. A host reaches it over a simple 8-bit I/O bus with an address, write data, combinational read data and one-cycle read and write strobes. After reset the block is locked in run state. In that state the configuration space is invisible and writes cannot change any register. Two consecutive writes of the unlock key 0x55 to the configuration port open the space. From then on the same address acts as an index port, and the next address acts as a data port that reaches the register the index names.

Global registers sit below index 0x30 and are shared by all devices: the logical-device selector, the identification bytes and the power enables. Registers from index 0x30 upward are held once per logical device and the selector picks which copy an access reaches. Each logical device drives an activate bit, two 16-bit base addresses and two interrupt numbers. One logical device also holds a small bank of GPIO function bytes. Writing the exit key 0xAA to the configuration port locks the block again. The peripheral functions themselves are outside this block.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is in run state (`cfg_mode`=0). The logical-device selector is 0, and every activate, power, base, interrupt and GPIO output is 0.
- R2: The block enters configuration state only after two back-to-back writes of 0x55 to port 0x3F0. Any other write between them, to any address or with any value, restarts the sequence.
- R3: In configuration state, a write of 0xAA to port 0x3F0 returns the block to run state and leaves the index unchanged.
- R4: In run state, writes to port 0x3F1 have no effect, and reads of port 0x3F0 or 0x3F1 return 0xFF.
- R5: In configuration state, any write to port 0x3F0 other than 0xAA loads the index register, and a read of 0x3F0 returns the index. Reads and writes of port 0x3F1 reach the register the index selects. When read and write strobes fall in the same cycle, the read returns the value held before the write.
- R6: Indices 0x20 and 0x21 are read-only. They return the device ID (default 0x30) and the revision (default 0x01).
- R7: Index 0x07 holds the logical-device number and can be read back. Indices 0x30 and above reach the copy that belongs to this number. When the number is 9 or higher, those writes are ignored and those reads return 0x00.
- R8: Index 0x30 bit 0 drives `dev_active[n]` for the selected device n. It reads back as 0x00 or 0x01.
- R9: Indices 0x60 (high byte) and 0x61 (low byte) form the primary base address on `dev_base_pri[16n +: 16]`. Indices 0x62 and 0x63 form the secondary base on `dev_base_sec[16n +: 16]` in the same way.
- R10: Index 0x70 drives `dev_irq_pri[8n +: 8]` and index 0x72 drives `dev_irq_sec[8n +: 8]` for the selected device n.
- R11: Global index 0x22 drives `dev_power`, where bit n powers device n. It reads back as written.
- R12: With logical device 8 selected, indices 0xC2, 0xC5, 0xC6 and 0xC7 store `gpio_func` bytes 0, 1, 2 and 3. With any other device selected, these indices read 0x00.
- R13: Unimplemented indices, global or banked, read 0x00. Reads of any address other than 0x3F0 and 0x3F1 also return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 12 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational from address and state |
| cfg_mode | output | 1 | High while in configuration state |
| dev_active | output | 9 | Activate bit per logical device |
| dev_power | output | 8 | Power enable per logical device 0 to 7 |
| dev_base_pri | output | 144 | Primary base address, 16 bits per device |
| dev_base_sec | output | 144 | Secondary base address, 16 bits per device |
| dev_irq_pri | output | 72 | Primary interrupt number, 8 bits per device |
| dev_irq_sec | output | 72 | Secondary interrupt number, 8 bits per device |
| gpio_func | output | 32 | GPIO function bytes of logical device 8 |

## Verification
A read and a write of the data port can fall in the same cycle. The read data comes from the stored registers, while the write lands on the clock edge that ends that cycle. The bench raises both strobes together on the power register, which already holds 0x02, and writes 0x80. The read sampled in that cycle must show 0x02, and a separate read afterwards must show 0x80. A change of device selector followed at once by a banked access is also checked, so that the new bank is used from the very next cycle.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_ENTER = 8'h55;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;

  localparam logic [7:0] IX_LDN    = 8'h07;
  localparam logic [7:0] IX_ID     = 8'h20;
  localparam logic [7:0] IX_REV    = 8'h21;
  localparam logic [7:0] IX_PWR    = 8'h22;
  localparam logic [7:0] IX_BANK   = 8'h30;
  localparam logic [7:0] IX_ACT    = 8'h30;
  localparam logic [7:0] IX_BP_HI  = 8'h60;
  localparam logic [7:0] IX_BP_LO  = 8'h61;
  localparam logic [7:0] IX_BS_HI  = 8'h62;
  localparam logic [7:0] IX_BS_LO  = 8'h63;
  localparam logic [7:0] IX_IRQ_P  = 8'h70;
  localparam logic [7:0] IX_IRQ_S  = 8'h72;

  localparam int GPIO_N = 4;
  localparam logic [7:0] GPIO_IDX [GPIO_N] = '{8'hC2, 8'hC5, 8'hC6, 8'hC7};

  typedef enum logic [1:0] {
    KS_RUN  = 2'd0,
    KS_HALF = 2'd1,
    KS_CFG  = 2'd2
  } key_st_t;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_wr,
  input  logic       wr_cfg,
  input  logic [7:0] wdata,
  output logic       cfg_mode
);
  key_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      KS_RUN:  if (wr_cfg && wdata == KEY_ENTER) st_d = KS_HALF;
      KS_HALF: if (any_wr) st_d = (wr_cfg && wdata == KEY_ENTER) ? KS_CFG : KS_RUN;
      KS_CFG:  if (wr_cfg && wdata == KEY_EXIT) st_d = KS_RUN;
      default: st_d = KS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_RUN;
    else        st_q <= st_d;
  end

  assign cfg_mode = (st_q == KS_CFG);

  // R2: configuration state is reached only through a key write
  a_r2_enter_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(wr_cfg && wdata == KEY_ENTER));

  // R3: the exit key leaves configuration state
  a_r3_exit_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && wr_cfg && wdata == KEY_EXIT) |=> !cfg_mode);
endmodule

// File: rtl/sio_ldev_regs.sv
module sio_ldev_regs
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        act_o,
  output logic [15:0] base_pri_o,
  output logic [15:0] base_sec_o,
  output logic [7:0]  irq_pri_o,
  output logic [7:0]  irq_sec_o,
  output logic [7:0]  rd_o
);
  logic       act_q, act_d;
  logic [7:0] bph_q, bph_d, bpl_q, bpl_d, bsh_q, bsh_d, bsl_q, bsl_d;
  logic [7:0] ip_q, ip_d, is_q, is_d;

  always_comb begin
    act_d = act_q;
    bph_d = bph_q; bpl_d = bpl_q;
    bsh_d = bsh_q; bsl_d = bsl_q;
    ip_d  = ip_q;  is_d  = is_q;
    if (wr_en) begin
      case (idx)
        IX_ACT:   act_d = wdata[0];
        IX_BP_HI: bph_d = wdata;
        IX_BP_LO: bpl_d = wdata;
        IX_BS_HI: bsh_d = wdata;
        IX_BS_LO: bsl_d = wdata;
        IX_IRQ_P: ip_d  = wdata;
        IX_IRQ_S: is_d  = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      bph_q <= '0; bpl_q <= '0; bsh_q <= '0; bsl_q <= '0;
      ip_q  <= '0; is_q  <= '0;
    end else begin
      act_q <= act_d;
      bph_q <= bph_d; bpl_q <= bpl_d; bsh_q <= bsh_d; bsl_q <= bsl_d;
      ip_q  <= ip_d;  is_q  <= is_d;
    end
  end

  always_comb begin
    case (idx)
      IX_ACT:   rd_o = {7'd0, act_q};
      IX_BP_HI: rd_o = bph_q;
      IX_BP_LO: rd_o = bpl_q;
      IX_BS_HI: rd_o = bsh_q;
      IX_BS_LO: rd_o = bsl_q;
      IX_IRQ_P: rd_o = ip_q;
      IX_IRQ_S: rd_o = is_q;
      default:  rd_o = 8'h00;
    endcase
  end

  assign act_o      = act_q;
  assign base_pri_o = {bph_q, bpl_q};
  assign base_sec_o = {bsh_q, bsl_q};
  assign irq_pri_o  = ip_q;
  assign irq_sec_o  = is_q;

  // R7: a device copy changes only when its bank is addressed
  a_r7_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(act_o) && $stable(base_pri_o) && $stable(base_sec_o)
                && $stable(irq_pri_o) && $stable(irq_sec_o)));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int               ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CFG_PORT = 12'h3F0,
  parameter logic [ADDR_W-1:0] DAT_PORT = 12'h3F1,
  parameter int               NUM_LDEV  = 9,
  parameter int               GPIO_LDN  = 8,
  parameter logic [7:0]       DEV_ID    = 8'h30,
  parameter logic [7:0]       DEV_REV   = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic [7:0]            io_wdata,
  input  logic                  io_wr,
  input  logic                  io_rd,
  output logic [7:0]            io_rdata,
  output logic                  cfg_mode,
  output logic [NUM_LDEV-1:0]   dev_active,
  output logic [7:0]            dev_power,
  output logic [16*NUM_LDEV-1:0] dev_base_pri,
  output logic [16*NUM_LDEV-1:0] dev_base_sec,
  output logic [8*NUM_LDEV-1:0] dev_irq_pri,
  output logic [8*NUM_LDEV-1:0] dev_irq_sec,
  output logic [8*GPIO_N-1:0]   gpio_func
);
  localparam logic [7:0] GPIO_LDN_B = 8'(GPIO_LDN);

  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic wr_cfg, wr_dat, at_cfg, at_dat;
  assign at_cfg = (io_addr == CFG_PORT);
  assign at_dat = (io_addr == DAT_PORT);
  assign wr_cfg = io_wr && at_cfg;
  assign wr_dat = io_wr && at_dat && cfg_mode;

  sio_key_fsm u_key (
    .clk(clk), .rst_n(rst_i), .any_wr(io_wr), .wr_cfg(wr_cfg),
    .wdata(io_wdata), .cfg_mode(cfg_mode)
  );

  // global registers
  logic [7:0] idx_q, idx_d, ldn_q, ldn_d, pwr_q, pwr_d;
  always_comb begin
    idx_d = idx_q;
    ldn_d = ldn_q;
    pwr_d = pwr_q;
    if (wr_cfg && cfg_mode && io_wdata != KEY_EXIT) idx_d = io_wdata;
    if (wr_dat && idx_q == IX_LDN) ldn_d = io_wdata;
    if (wr_dat && idx_q == IX_PWR) pwr_d = io_wdata;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      idx_q <= '0; ldn_q <= '0; pwr_q <= '0;
    end else begin
      idx_q <= idx_d; ldn_q <= ldn_d; pwr_q <= pwr_d;
    end
  end
  assign dev_power = pwr_q;

  // per-device banks
  logic [7:0] bank_rd [NUM_LDEV];
  for (genvar d = 0; d < NUM_LDEV; d++) begin : g_ldev
    logic wr_bank;
    assign wr_bank = wr_dat && (idx_q >= IX_BANK) && (ldn_q == 8'(d));
    sio_ldev_regs u_regs (
      .clk(clk), .rst_n(rst_i), .wr_en(wr_bank), .idx(idx_q), .wdata(io_wdata),
      .act_o(dev_active[d]),
      .base_pri_o(dev_base_pri[16*d +: 16]),
      .base_sec_o(dev_base_sec[16*d +: 16]),
      .irq_pri_o(dev_irq_pri[8*d +: 8]),
      .irq_sec_o(dev_irq_sec[8*d +: 8]),
      .rd_o(bank_rd[d])
    );
  end

  // GPIO function bytes in the GPIO logical device
  logic gpio_sel;
  assign gpio_sel = (ldn_q == GPIO_LDN_B);
  for (genvar g = 0; g < GPIO_N; g++) begin : g_gpio
    logic [7:0] gb_q, gb_d;
    always_comb begin
      gb_d = gb_q;
      if (wr_dat && gpio_sel && idx_q == GPIO_IDX[g]) gb_d = io_wdata;
    end
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) gb_q <= '0;
      else        gb_q <= gb_d;
    end
    assign gpio_func[8*g +: 8] = gb_q;
  end

  // read path
  logic [7:0] bank_sel;
  always_comb begin
    bank_sel = 8'h00;
    for (int d = 0; d < NUM_LDEV; d++)
      if (ldn_q == 8'(d)) bank_sel = bank_rd[d];
    if (gpio_sel)
      for (int g = 0; g < GPIO_N; g++)
        if (idx_q == GPIO_IDX[g]) bank_sel = bank_sel | gpio_func[8*g +: 8];
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && (at_cfg || at_dat)) begin
      if (!cfg_mode)   io_rdata = 8'hFF;
      else if (at_cfg) io_rdata = idx_q;
      else begin
        case (idx_q)
          IX_LDN:  io_rdata = ldn_q;
          IX_ID:   io_rdata = DEV_ID;
          IX_REV:  io_rdata = DEV_REV;
          IX_PWR:  io_rdata = pwr_q;
          default: io_rdata = (idx_q >= IX_BANK) ? bank_sel : 8'h00;
        endcase
      end
    end
  end

  // R4: in run state no write can reach a stored register
  a_r4_run_no_change: assert property (@(posedge clk) disable iff (!rst_i)
    (!cfg_mode && io_wr) |=> ($stable(dev_active) && $stable(dev_power)
                              && $stable(gpio_func) && $stable(dev_base_pri)));

  // R11: power enables move only on a configuration-state data write
  a_r11_power_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !(io_wr && at_dat && cfg_mode) |=> $stable(dev_power));

  // R12: GPIO bytes move only while the GPIO device is selected
  a_r12_gpio_bank: assert property (@(posedge clk) disable iff (!rst_i)
    !gpio_sel |=> $stable(gpio_func));
endmodule

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;
  localparam logic [11:0] CP = 12'h3F0;
  localparam logic [11:0] DP = 12'h3F1;

  logic clk = 1'b0;
  logic rst_n;
  logic [11:0] io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic        io_wr, io_rd, cfg_mode;
  logic [8:0]  dev_active;
  logic [7:0]  dev_power;
  logic [143:0] dev_base_pri, dev_base_sec;
  logic [71:0]  dev_irq_pri, dev_irq_sec;
  logic [31:0]  gpio_func;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
    .dev_active(dev_active), .dev_power(dev_power),
    .dev_base_pri(dev_base_pri), .dev_base_sec(dev_base_sec),
    .dev_irq_pri(dev_irq_pri), .dev_irq_sec(dev_irq_sec),
    .gpio_func(gpio_func)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic setreg(input logic [7:0] ix, input logic [7:0] d);
    wr(CP, ix); wr(DP, d);
  endtask

  task automatic getreg(input logic [7:0] ix, output logic [7:0] d);
    wr(CP, ix); rd(DP, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 cfg_mode", cfg_mode, 0);
    chk("R1 outputs", {23'd0, dev_active} | dev_power | gpio_func
        | dev_base_pri[31:0] | dev_irq_pri[31:0], 0);
    rd(DP, v); chk("R4 run read data", v, 8'hFF);
    rd(CP, v); chk("R4 run read index", v, 8'hFF);
    rd(12'h100, v); chk("R13 other address", v, 8'h00);
  endtask

  task automatic t_run_ignore;
    wr(DP, 8'h33);
    chk("R4 run write power", dev_power, 0);
    chk("R4 still run", cfg_mode, 0);
  endtask

  task automatic t_unlock;
    wr(CP, 8'h55); wr(DP, 8'h00); wr(CP, 8'h55);
    chk("R2 broken sequence", cfg_mode, 0);
    wr(CP, 8'h55);
    chk("R2 unlock", cfg_mode, 1);
  endtask

  task automatic t_index_id;
    logic [7:0] v;
    wr(CP, 8'h20); rd(CP, v); chk("R5 index readback", v, 8'h20);
    rd(DP, v); chk("R6 device id", v, 8'h30);
    wr(DP, 8'h99); rd(DP, v); chk("R6 id read-only", v, 8'h30);
    getreg(8'h21, v); chk("R6 revision", v, 8'h01);
    getreg(8'h07, v); chk("R7 ldn reset", v, 8'h00);
  endtask

  task automatic t_banks;
    logic [7:0] v;
    setreg(8'h07, 8'h01);
    setreg(8'h30, 8'hFF);
    chk("R8 activate dev1", dev_active, 9'h002);
    getreg(8'h30, v); chk("R8 activate readback", v, 8'h01);
    setreg(8'h60, 8'h01); setreg(8'h61, 8'hF0);
    setreg(8'h62, 8'h03); setreg(8'h63, 8'hF6);
    chk("R9 primary base dev1", dev_base_pri[31:16], 16'h01F0);
    chk("R9 secondary base dev1", dev_base_sec[31:16], 16'h03F6);
    setreg(8'h70, 8'h0E);
    chk("R10 irq dev1", dev_irq_pri[15:8], 8'h0E);
    setreg(8'h07, 8'h07);
    setreg(8'h30, 8'h01); setreg(8'h70, 8'h01); setreg(8'h72, 8'h0C);
    chk("R8 activate dev7", dev_active, 9'h082);
    chk("R10 primary irq dev7", dev_irq_pri[63:56], 8'h01);
    chk("R10 secondary irq dev7", dev_irq_sec[63:56], 8'h0C);
    chk("R7 dev1 irq kept", dev_irq_pri[15:8], 8'h0E);
    getreg(8'h70, v); chk("R7 read dev7 irq", v, 8'h01);
    setreg(8'h07, 8'h01); rd(DP, v); chk("R7 ldn readback", v, 8'h01);
    getreg(8'h70, v); chk("R7 read dev1 irq", v, 8'h0E);
    getreg(8'h40, v); chk("R13 banked unimplemented", v, 8'h00);
    getreg(8'h10, v); chk("R13 global unimplemented", v, 8'h00);
    setreg(8'h07, 8'h09); setreg(8'h30, 8'h01);
    chk("R7 out of range write", dev_active, 9'h082);
    rd(DP, v); chk("R7 out of range read", v, 8'h00);
  endtask

  task automatic t_power;
    logic [7:0] v;
    setreg(8'h22, 8'h02);
    chk("R11 power", dev_power, 8'h02);
    rd(DP, v); chk("R11 power readback", v, 8'h02);
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    setreg(8'h07, 8'h08);
    setreg(8'hC2, 8'h00); setreg(8'hC5, 8'h01);
    setreg(8'hC6, 8'hA5); setreg(8'hC7, 8'h3C);
    chk("R12 gpio bytes", gpio_func, 32'h3CA50100);
    getreg(8'hC6, v); chk("R12 gpio readback", v, 8'hA5);
    setreg(8'h07, 8'h01); getreg(8'hC6, v);
    chk("R12 gpio other device", v, 8'h00);
    setreg(8'hC7, 8'h77);
    chk("R12 gpio write other device", gpio_func, 32'h3CA50100);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    wr(CP, 8'h22);
    @(negedge clk);
    io_addr = DP; io_wdata = 8'h80; io_wr = 1'b1; io_rd = 1'b1;
    #1 v = io_rdata;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    chk("R5 same-cycle read old", v, 8'h02);
    rd(DP, v); chk("R5 same-cycle write lands", v, 8'h80);
  endtask

  task automatic t_exit;
    logic [7:0] v;
    wr(CP, 8'hAA);
    chk("R3 exit", cfg_mode, 0);
    rd(DP, v); chk("R4 run read after exit", v, 8'hFF);
    wr(DP, 8'h00);
    chk("R4 power kept", dev_power, 8'h80);
    wr(CP, 8'h55); wr(CP, 8'h55);
    rd(CP, v); chk("R3 index kept", v, 8'h22);
  endtask

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_run_ignore();
    t_unlock();
    t_index_id();
    t_banks();
    t_power();
    t_gpio();
    t_same_cycle();
    t_exit();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule